// File: doc/BRIEF.md
# Debug Variable Tap with History, Override and Rewind

The block sits inline on one signal of interest inside a larger design. It passes the signal through to its downstream consumer and records every captured value into a circular history held on chip. Each record carries the value together with a cycle stamp, which counts enabled cycles since reset. Captured records also flow out of a drain stream so that a memory controller outside the block can move them to external storage. When that stream holds back and local space runs short, the block raises a stall request so that the surrounding design can stop its enable.

A host reaches the block through a plain register port: one write strobe, a 3-bit address, 32-bit write data and read data that follows the address combinationally. Through that port the host can read the live value and any stored record. It can force a replacement value downstream, either once or persistently. It can rewind by replaying the newest N records, oldest first. It can also thin the capture rate with a sample divider. Drain rules: `drn_valid` is high whenever an undrained record exists, and a record leaves only in a cycle where `drn_valid` and `drn_ready` are both high. While the stream is held back, data and stamp stay unchanged unless an overflow discards the oldest pending record.

Top module: `dbg_var_tap`

## Requirements
- R1: With no replay and no override active, `var_out` equals `var_in` in the same cycle.
- R2: A capture stores the value on `var_out` and the stamp counter's current value. The history keeps the newest 64 records. Address 3 reads the number held, which saturates at 64. Address 4 holds a selector k. Addresses 5 and 6 read the value and stamp of the k-th newest record, with 0 meaning the newest, and read 0 when k is not below the number held.
- R3: Address 1 reads the current `var_out` (zero-extended). Address 7 reads the stamp counter, which advances by one on every cycle with `en` high.
- R4: A write to address 1 loads an override value and arms a one-shot. From the next cycle, `var_out` shows that value until the end of the first enabled cycle without replay.
- R5: While bit 0 of the control register (address 0) is set, `var_out` shows the override value in every cycle that is not replaying.
- R6: A write of N to address 3 with 1 <= N <= number held starts a replay. From the next cycle, `var_out` shows the newest N records' values, oldest first, advancing one per enabled cycle. Replay has priority over override. Control bit 1 reads 1 while it runs. No capture is made and the divider phase is frozen during replay. The error bit is cleared.
- R7: A write to address 3 with N = 0 or N greater than the number held leaves history and output untouched and sets control bit 2 (error).
- R8: Address 2 holds the sample divider D, with reset value 1. A capture occurs on the first enabled, non-replay cycle after reset or after a write to address 2, and then on every D-th such cycle. D = 0 acts as 1.
- R9: The drain stream delivers every captured record in capture order. `drn_valid` stays high while not accepted, and data and stamp hold unless an overflow occurs.
- R10: `stall_req` is high exactly when `drn_ready` is low and 60 or more records (depth minus 4) are pending. A capture while 64 records are pending and none leaves discards the oldest pending record.
- R11: After reset, `var_out` follows `var_in`, `drn_valid` and `stall_req` are low, the count, stamp and control read 0, and the divider reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable of the observed design; one enabled cycle is one step |
| var_in | input | 16 | Signal from the producer |
| var_out | output | 16 | Signal to the consumer |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for `host_addr` |
| drn_valid | output | 1 | Drain record available |
| drn_ready | input | 1 | Drain consumer accepts |
| drn_val | output | 16 | Drain record value |
| drn_stamp | output | 32 | Drain record cycle stamp |
| stall_req | output | 1 | Request to hold the observed design's enable |

## Verification
The assertions take for granted that reset is applied before the first checked edge, that the history depth is a power of two, and that `en`, `drn_ready` and the host port hold steady between clock edges. They make no assumption that `stall_req` is obeyed. The stimulus changes every input only at the falling edge. It lets `drn_ready` drop for long stretches while `en` keeps running, so the stall and overflow paths are reached. It uses only the eight defined register addresses.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;
  localparam int unsigned HOST_AW = 3;
  localparam int unsigned HOST_DW = 32;

  localparam logic [HOST_AW-1:0] A_CTRL   = 3'd0;
  localparam logic [HOST_AW-1:0] A_VALUE  = 3'd1;
  localparam logic [HOST_AW-1:0] A_DIV    = 3'd2;
  localparam logic [HOST_AW-1:0] A_REWIND = 3'd3;
  localparam logic [HOST_AW-1:0] A_HSEL   = 3'd4;
  localparam logic [HOST_AW-1:0] A_HVAL   = 3'd5;
  localparam logic [HOST_AW-1:0] A_HSTAMP = 3'd6;
  localparam logic [HOST_AW-1:0] A_STAMP  = 3'd7;

  localparam int unsigned CB_STICKY = 0;
  localparam int unsigned CB_REPLAY = 1;
  localparam int unsigned CB_ERR    = 2;
endpackage

// File: rtl/dbg_tap_hist.sv
module dbg_tap_hist #(
  parameter int unsigned W      = 16,
  parameter int unsigned SW     = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned MARGIN = 4,
  parameter int unsigned NRD    = 2,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned EW    = W + SW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [W-1:0]           push_val,
  input  logic [SW-1:0]          push_stamp,
  output logic [AW-1:0]          wr_ptr,
  output logic [AW:0]            count,
  input  logic [NRD-1:0][AW-1:0] rd_idx,
  output logic [NRD-1:0][EW-1:0] rd_ent,
  output logic                   drn_valid,
  input  logic                   drn_ready,
  output logic [W-1:0]           drn_val,
  output logic [SW-1:0]          drn_stamp,
  output logic                   stall_req
);
  localparam logic [AW:0] FULL_CNT  = (AW+1)'(DEPTH);
  localparam logic [AW:0] STALL_CNT = (AW+1)'(DEPTH - MARGIN);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr;
  logic [AW:0]   pend;
  logic          pop, drop, adv;

  assign pop  = (pend != '0) && drn_ready;
  assign drop = push && (pend == FULL_CNT) && !drn_ready;
  assign adv  = pop | drop;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_stamp, push_val};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      pend   <= '0;
    end else begin
      if (push) begin
        wr_ptr <= wr_ptr + AW'(1);
        if (count != FULL_CNT) count <= count + (AW+1)'(1);
      end
      if (adv) rd_ptr <= rd_ptr + AW'(1);
      pend <= pend + (AW+1)'(push) - (AW+1)'(adv);
    end
  end

  generate
    for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rd_ent[g] = mem[rd_idx[g]];
    end
  endgenerate

  assign drn_valid = (pend != '0);
  assign {drn_stamp, drn_val} = mem[rd_ptr];
  assign stall_req = !drn_ready && (pend >= STALL_CNT);

  // R9: an offered record is not withdrawn before acceptance
  a_r9_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    drn_valid && !drn_ready |=> drn_valid);
  // R9: offered record stays put unless an overflow discards it
  a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    drn_valid && !drn_ready && !(push && pend == FULL_CNT) |=> $stable({drn_stamp, drn_val}));
  // R2: history count never exceeds its depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R10: pending records never exceed storage
  a_r10_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= FULL_CNT);
endmodule

// File: rtl/dbg_tap_ctrl.sv
module dbg_tap_ctrl
  import dbg_tap_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned SW    = 32,
  parameter int unsigned DIV_W = 16,
  parameter int unsigned AW    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  input  logic [AW-1:0]      wr_ptr,
  input  logic [AW:0]        count,
  output logic               cap,
  output logic [SW-1:0]      stamp,
  output logic               sticky,
  output logic               ovr_pend,
  output logic [W-1:0]       ovr_val,
  output logic               rp_active,
  output logic [AW-1:0]      rp_idx,
  output logic [HOST_DW-1:0] hsel,
  output logic [DIV_W-1:0]   div,
  output logic               err
);
  logic [DIV_W-1:0] phase, div_eff;
  logic [DIV_W:0]   phase_inc;
  logic [AW:0]      rp_left;
  logic             wr_ctrl, wr_value, wr_div, wr_rew, wr_hsel, rew_ok;

  assign wr_ctrl  = host_wr && (host_addr == A_CTRL);
  assign wr_value = host_wr && (host_addr == A_VALUE);
  assign wr_div   = host_wr && (host_addr == A_DIV);
  assign wr_rew   = host_wr && (host_addr == A_REWIND);
  assign wr_hsel  = host_wr && (host_addr == A_HSEL);
  assign rew_ok   = (host_wdata != '0) && (host_wdata <= HOST_DW'(count));

  assign div_eff   = (div == '0) ? DIV_W'(1) : div;
  assign phase_inc = {1'b0, phase} + (DIV_W+1)'(1);
  assign rp_active = (rp_left != '0);
  assign cap       = en && !rp_active && (phase == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp    <= '0;
      phase    <= '0;
      div      <= DIV_W'(1);
      sticky   <= 1'b0;
      ovr_pend <= 1'b0;
      ovr_val  <= '0;
      rp_left  <= '0;
      rp_idx   <= '0;
      err      <= 1'b0;
      hsel     <= '0;
    end else begin
      if (en) stamp <= stamp + SW'(1);
      if (en && rp_active) begin
        rp_idx  <= rp_idx + AW'(1);
        rp_left <= rp_left - (AW+1)'(1);
      end
      if (en && !rp_active) begin
        ovr_pend <= 1'b0;
        phase    <= (phase_inc >= {1'b0, div_eff}) ? '0 : phase_inc[DIV_W-1:0];
      end
      if (wr_value) begin
        ovr_val  <= host_wdata[W-1:0];
        ovr_pend <= 1'b1;
      end
      if (wr_ctrl) sticky <= host_wdata[CB_STICKY];
      if (wr_div) begin
        div   <= host_wdata[DIV_W-1:0];
        phase <= '0;
      end
      if (wr_hsel) hsel <= host_wdata;
      if (wr_rew) begin
        if (rew_ok) begin
          rp_idx  <= wr_ptr - host_wdata[AW-1:0];
          rp_left <= host_wdata[AW:0];
          err     <= 1'b0;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  // R7: a rewind deeper than the history (or of zero) raises the error bit
  a_r7_reject_err: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == A_REWIND && (host_wdata == '0 || host_wdata > HOST_DW'(count)) |=> err);
  // R4: the one-shot is consumed by one enabled non-replay cycle
  a_r4_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_pend && en && !rp_active && !wr_value |=> !ovr_pend);
  // R3: stamp steps by one per enabled cycle and holds otherwise
  a_r3_stamp_step: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> stamp == $past(stamp) + SW'(1));
  a_r3_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(stamp));
  // R8: phase stays inside the divider period
  a_r8_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phase == '0 || phase < div_eff);
endmodule

// File: rtl/dbg_var_tap.sv
module dbg_var_tap
  import dbg_tap_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned SW     = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned MARGIN = 4,
  parameter int unsigned DIV_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [W-1:0]       var_in,
  output logic [W-1:0]       var_out,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               drn_valid,
  input  logic               drn_ready,
  output logic [W-1:0]       drn_val,
  output logic [SW-1:0]      drn_stamp,
  output logic               stall_req
);
  localparam int unsigned AW  = $clog2(DEPTH);
  localparam int unsigned EW  = W + SW;
  localparam int unsigned NRD = 2;
  localparam int unsigned RP_PORT = 0;
  localparam int unsigned HO_PORT = 1;

  logic                   cap, sticky, ovr_pend, rp_active, err;
  logic [SW-1:0]          stamp;
  logic [W-1:0]           ovr_val;
  logic [AW-1:0]          rp_idx, wr_ptr;
  logic [AW:0]            count;
  logic [HOST_DW-1:0]     hsel;
  logic [DIV_W-1:0]       div;
  logic [NRD-1:0][AW-1:0] rd_idx;
  logic [NRD-1:0][EW-1:0] rd_ent;
  logic                   hsel_ok;
  logic [SW-1:0]          unused_rp_stamp;

  dbg_tap_ctrl #(.W(W), .SW(SW), .DIV_W(DIV_W), .AW(AW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .wr_ptr(wr_ptr), .count(count), .cap(cap), .stamp(stamp),
    .sticky(sticky), .ovr_pend(ovr_pend), .ovr_val(ovr_val),
    .rp_active(rp_active), .rp_idx(rp_idx), .hsel(hsel), .div(div), .err(err)
  );

  dbg_tap_hist #(.W(W), .SW(SW), .DEPTH(DEPTH), .MARGIN(MARGIN), .NRD(NRD)) i_hist (
    .clk(clk), .rst_n(rst_n), .push(cap), .push_val(var_out), .push_stamp(stamp),
    .wr_ptr(wr_ptr), .count(count), .rd_idx(rd_idx), .rd_ent(rd_ent),
    .drn_valid(drn_valid), .drn_ready(drn_ready), .drn_val(drn_val),
    .drn_stamp(drn_stamp), .stall_req(stall_req)
  );

  assign rd_idx[RP_PORT] = rp_idx;
  assign rd_idx[HO_PORT] = wr_ptr - AW'(1) - hsel[AW-1:0];
  assign hsel_ok         = hsel < HOST_DW'(count);
  assign unused_rp_stamp = rd_ent[RP_PORT][EW-1:W];

  always_comb begin
    if (rp_active)               var_out = rd_ent[RP_PORT][W-1:0];
    else if (sticky || ovr_pend) var_out = ovr_val;
    else                         var_out = var_in;
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_CTRL: begin
        host_rdata[CB_STICKY] = sticky;
        host_rdata[CB_REPLAY] = rp_active;
        host_rdata[CB_ERR]    = err;
      end
      A_VALUE:  host_rdata = HOST_DW'(var_out);
      A_DIV:    host_rdata = HOST_DW'(div);
      A_REWIND: host_rdata = HOST_DW'(count);
      A_HSEL:   host_rdata = hsel;
      A_HVAL:   host_rdata = hsel_ok ? HOST_DW'(rd_ent[HO_PORT][W-1:0]) : '0;
      A_HSTAMP: host_rdata = hsel_ok ? HOST_DW'(rd_ent[HO_PORT][EW-1:W]) : '0;
      default:  host_rdata = HOST_DW'(stamp);
    endcase
  end

  // R6: history write pointer stays frozen while a replay runs
  a_r6_history_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rp_active |=> $stable(wr_ptr));
  // R2: a capture grows the history unless it is already full
  a_r2_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
    cap && count < (AW+1)'(DEPTH) |=> count == $past(count) + (AW+1)'(1));
endmodule

// File: tb/test_dbg_var_tap.sv
module test_dbg_var_tap;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int SW = 32;
  localparam int DEPTH = 64;
  localparam int MARGIN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [W-1:0] var_in = '0;
  logic [W-1:0] var_out;
  logic host_wr = 1'b0;
  logic [2:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic drn_valid;
  logic drn_ready = 1'b1;
  logic [W-1:0] drn_val;
  logic [SW-1:0] drn_stamp;
  logic stall_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_var_tap i_dbg_var_tap (
    .clk(clk), .rst_n(rst_n), .en(en), .var_in(var_in), .var_out(var_out),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .drn_valid(drn_valid), .drn_ready(drn_ready),
    .drn_val(drn_val), .drn_stamp(drn_stamp), .stall_req(stall_req)
  );

  int n_checks = 0;
  int n_fail = 0;

  // behavioural reference state
  logic [W+SW-1:0] m_hist[$];
  logic [W+SW-1:0] m_pend[$];
  logic [W-1:0]    m_rp[$];
  logic [SW-1:0]   m_stamp;
  int              m_phase;
  logic [15:0]     m_div;
  bit              m_sticky, m_opend, m_err;
  logic [W-1:0]    m_oval;
  logic [31:0]     m_hsel;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_hist.delete(); m_pend.delete(); m_rp.delete();
    m_stamp = '0; m_phase = 0; m_div = 16'd1;
    m_sticky = 0; m_opend = 0; m_err = 0; m_oval = '0; m_hsel = '0;
  endtask

  function automatic logic [W-1:0] m_out();
    if (m_rp.size() > 0) return m_rp[0];
    if (m_sticky || m_opend) return m_oval;
    return var_in;
  endfunction

  function automatic logic [31:0] m_rdata(logic [2:0] a);
    int k;
    k = int'(m_hsel);
    case (a)
      3'd0: return {29'd0, m_err, m_rp.size() > 0, m_sticky};
      3'd1: return 32'(m_out());
      3'd2: return 32'(m_div);
      3'd3: return 32'(m_hist.size());
      3'd4: return m_hsel;
      3'd5: return (m_hsel < 32'(m_hist.size())) ? 32'(m_hist[m_hist.size()-1-k][W-1:0]) : 32'd0;
      3'd6: return (m_hsel < 32'(m_hist.size())) ? 32'(m_hist[m_hist.size()-1-k][W+SW-1:W]) : 32'd0;
      default: return m_stamp;
    endcase
  endfunction

  function automatic string reg_tag(logic [2:0] a);
    case (a)
      3'd0: return "R7 ctrl";
      3'd1: return "R3 value";
      3'd2: return "R8 div";
      3'd7: return "R3 stamp";
      default: return "R2 history";
    endcase
  endfunction

  task automatic model_edge();
    logic [W-1:0] nrp[$];
    bit rp_act, cap, pop, rew_ok;
    logic [W-1:0] cur;
    int hsz, deff;
    rp_act = m_rp.size() > 0;
    cap = en && !rp_act && (m_phase == 0);
    cur = m_out();
    pop = (m_pend.size() > 0) && drn_ready;
    hsz = m_hist.size();
    rew_ok = (host_wdata != 0) && (host_wdata <= 32'(hsz));
    if (host_wr && host_addr == 3'd3 && rew_ok)
      for (int i = hsz - int'(host_wdata); i < hsz; i++) nrp.push_back(m_hist[i][W-1:0]);
    if (pop) void'(m_pend.pop_front());
    if (cap) begin
      if (m_pend.size() == DEPTH) void'(m_pend.pop_front());
      m_pend.push_back({m_stamp, cur});
      m_hist.push_back({m_stamp, cur});
      if (m_hist.size() > DEPTH) void'(m_hist.pop_front());
    end
    if (en) begin
      m_stamp++;
      if (rp_act) void'(m_rp.pop_front());
      else begin
        m_opend = 0;
        deff = (m_div == 0) ? 1 : int'(m_div);
        m_phase = (m_phase + 1 >= deff) ? 0 : m_phase + 1;
      end
    end
    if (host_wr) begin
      case (host_addr)
        3'd0: m_sticky = host_wdata[0];
        3'd1: begin m_oval = host_wdata[W-1:0]; m_opend = 1; end
        3'd2: begin m_div = host_wdata[15:0]; m_phase = 0; end
        3'd3: if (rew_ok) begin m_rp = nrp; m_err = 0; end else m_err = 1;
        3'd4: m_hsel = host_wdata;
        default: ;
      endcase
    end
  endtask

  task automatic compare_all();
    string vt;
    if (m_rp.size() > 0) vt = "R6 replay";
    else if (m_sticky) vt = "R5 sticky";
    else if (m_opend) vt = "R4 one-shot";
    else vt = "R1 pass";
    check(vt, 64'(var_out), 64'(m_out()));
    check("R10 stall", 64'(stall_req), 64'(!drn_ready && m_pend.size() >= DEPTH - MARGIN));
    check("R9 valid", 64'(drn_valid), 64'(m_pend.size() > 0));
    if (m_pend.size() > 0 && drn_valid)
      check("R9 record", {drn_stamp, drn_val}, 64'(m_pend[0]));
    check(reg_tag(host_addr), 64'(host_rdata), 64'(m_rdata(host_addr)));
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  // en_mode / rdy_mode: 0 always high, 1 random, 2 always low
  task automatic run(int n, int en_mode, int rdy_mode);
    for (int i = 0; i < n; i++) begin
      var_in = W'($urandom);
      en = (en_mode == 0) ? 1'b1 : (en_mode == 1) ? 1'($urandom) : 1'b0;
      drn_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'($urandom) : 1'b0;
      host_addr = 3'(i);
      cycle();
    end
  endtask

  task automatic host_write(logic [2:0] a, logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    cycle();
    host_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    model_reset();
    var_in = 16'h1234;
    repeat (3) @(negedge clk);
    // R11 reset state
    host_addr = 3'd3; #1;
    check("R11 out", 64'(var_out), 64'h1234);
    check("R11 valid", 64'(drn_valid), 64'd0);
    check("R11 stall", 64'(stall_req), 64'd0);
    check("R11 count", 64'(host_rdata), 64'd0);
    host_addr = 3'd7; #1; check("R11 stamp", 64'(host_rdata), 64'd0);
    host_addr = 3'd2; #1; check("R11 div", 64'(host_rdata), 64'd1);
    host_addr = 3'd0; #1; check("R11 ctrl", 64'(host_rdata), 64'd0);
    rst_n = 1'b1;

    run(20, 0, 0);                 // R1 R2 R9 plain capture
    en = 1'b0;
    host_write(3'd3, 32'd0);       // R7 zero depth
    run(4, 2, 0);
    host_write(3'd3, 32'd1000);    // R7 too deep
    run(4, 2, 0);
    en = 1'b0;
    host_write(3'd3, 32'd5);       // R6 replay newest five
    run(16, 1, 1);
    en = 1'b0;
    host_write(3'd1, 32'h0000BEEF); // R4 one-shot
    run(12, 1, 1);
    host_write(3'd0, 32'd1);       // R5 sticky
    run(10, 1, 0);
    host_write(3'd0, 32'd0);
    run(6, 0, 0);
    host_write(3'd2, 32'd3);       // R8 divide by three
    run(30, 1, 1);
    host_write(3'd2, 32'd0);       // R8 zero acts as one
    run(10, 0, 1);
    host_write(3'd2, 32'd1);
    for (int k = 0; k < 4; k++) begin  // R2 history selector
      en = 1'b0;
      host_write(3'd4, (k == 3) ? 32'd70 : 32'(k * 7));
      run(8, 2, 0);
    end
    run(90, 0, 2);                 // R10 stall and overflow
    run(40, 1, 2);
    run(150, 1, 1);                // R9 draining
    en = 1'b0;
    host_write(3'd3, 32'd65);      // R7 beyond full history
    run(4, 2, 0);
    host_write(3'd3, 32'd64);      // R6 full-depth replay
    host_write(3'd1, 32'h00005A5A); // override armed during replay
    run(80, 1, 1);
    host_write(3'd4, 32'd63);
    run(16, 0, 0);
    finish_run();
  end
endmodule